// File: doc/BRIEF.md
# Flash Write-Control and Security Register

This block is one special-function register of a small microcontroller core. It decides where the core's external data-move write cycles land. A write goes to program flash only when the core has armed flash programming and the move uses the data pointer as its address. In every other case the write goes to data RAM. The same register also arms a single mass-erase operation for the flash sequencer. It holds a security latch that, once set, stays set until chip reset. While the latch is set, the block forces the read data that an external debug path sees from flash and coprocessor RAM to zero.

Software reaches the register through the core's SFR bus at one fixed address. The flash sequencer receives three control outputs: a program-write enable, a mass-erase request and a secure flag. The sequencer returns two pulses, one when a flash byte has been written and one when an erase has finished. A preboot-active status input is shown read-only in the top bit. The block does only gating and status; the flash timing and the erase sequencing live elsewhere.

Top module: `fwc_flash_ctl`

## Requirements
- R1: After reset the program-write enable, the erase request and the secure flag are 0. A read at the register address returns only the preboot bit (bit 7).
- R2: An SFR write at address SFR_ADDR (default 0xB2) with the interrupt-enable input low loads wdata bit 0 into the program-write enable, visible on `pgm_wr_en` and read bit 0 from the next cycle. Writes at any other address change nothing.
- R3: While `int_en` is 1, an SFR write leaves the program-write enable unchanged. Bits 1 and 6 of the same write still take effect.
- R4: A `flash_byte_done` pulse clears the program-write enable on the next cycle. If a permitted SFR write occurs in the same cycle, the written value wins.
- R5: On each cycle with `mov_wr` high, exactly one strobe is asserted in that same cycle. `flash_wr_stb` is asserted when the program-write enable is 1 and `mov_via_dptr` is 1; otherwise `ram_wr_stb` is asserted. With `mov_wr` low, both strobes are 0.
- R6: Writing 1 to bit 1 raises `erase_req` from the next cycle, and writing 0 to bit 1 drops it. An `erase_done` pulse clears it unless a write to bit 1 occurs in the same cycle, in which case the write wins. Bit 1 always reads back as 0.
- R7: Writing 1 to bit 6 sets `secure`. Writing 0 to bit 6 has no effect, and only reset clears the flag. Read bit 6 shows the flag.
- R8: Read bit 7 follows the `preboot` input in the same cycle, and writes to bit 7 have no effect.
- R9: While `secure` is 1, `ext_rd_data_o` is 0. Otherwise it equals `ext_rd_data_i`.
- R10: `sfr_rdata` is 0 whenever `sfr_addr` is not SFR_ADDR, and read bits 2 to 5 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | SFR bus address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational) |
| int_en | input | 1 | Global interrupt enable of the core |
| mov_wr | input | 1 | External data-move write cycle, one cycle per write |
| mov_via_dptr | input | 1 | The move uses the data pointer as address |
| flash_wr_stb | output | 1 | Write strobe toward program flash |
| ram_wr_stb | output | 1 | Write strobe toward data RAM |
| flash_byte_done | input | 1 | Pulse: the sequencer finished a flash byte |
| erase_done | input | 1 | Pulse: the sequencer finished a mass erase |
| preboot | input | 1 | Preboot sequence active |
| pgm_wr_en | output | 1 | Program-write steering enable |
| erase_req | output | 1 | Mass-erase request |
| secure | output | 1 | Security latch |
| ext_rd_data_i | input | DW | Flash/coprocessor-RAM data bound for the debug readout |
| ext_rd_data_o | output | DW | The same data, forced to zero when secure |

## Verification
The bound checker covers the cycle-by-cycle rules. It checks that the two write strobes are mutually exclusive and that exactly one fires per move, that an interrupt-enabled write never changes the write enable, and that the completion pulses clear their bits unless a write overrides them. It also checks that the security flag never falls, that the masked readout is zero while secure, and how bits 1 and 7 read back. The directed scenarios show what the checker cannot express on its own. They cover the reset values, a written value appearing a cycle later, writes at other addresses leaving the state alone, writes of zero to the security bit being ignored, and the full arm-erase-rearm sequence.

// File: rtl/fwc_pkg.sv
package fwc_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned PWE_BIT    = 0;
    localparam int unsigned ERASE_BIT  = 1;
    localparam int unsigned SECURE_BIT = 6;
    localparam int unsigned PREBOOT_BIT = 7;

    typedef struct packed {
        logic secure;
        logic erase;
        logic pwe;
    } ctrl_t;

    typedef enum logic [1:0] {
        ROUTE_IDLE  = 2'd0,
        ROUTE_RAM   = 2'd1,
        ROUTE_FLASH = 2'd2
    } route_t;

    // Readback image: erase arm is write-only, spare bits are zero.
    function automatic logic [BYTE_W-1:0] status_byte(ctrl_t c, logic preboot_act);
        logic [BYTE_W-1:0] b;
        b              = '0;
        b[PWE_BIT]     = c.pwe;
        b[SECURE_BIT]  = c.secure;
        b[PREBOOT_BIT] = preboot_act;
        return b;
    endfunction

    function automatic route_t pick_route(logic wr, logic via_dptr, logic pwe);
        if (!wr)
            return ROUTE_IDLE;
        else if (pwe && via_dptr)
            return ROUTE_FLASH;
        else
            return ROUTE_RAM;
    endfunction

endpackage

// File: rtl/fwc_bit_ctrl.sv
module fwc_bit_ctrl
    import fwc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              int_en,
    input  logic              byte_done,
    input  logic              erase_done,
    output ctrl_t             q
);

    logic pwe_wr_ok;
    assign pwe_wr_ok = wr_hit && !int_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            // Hardware completion clears first; a permitted write overrides.
            if (byte_done)
                q.pwe <= 1'b0;
            if (pwe_wr_ok)
                q.pwe <= wdata[PWE_BIT];

            if (erase_done)
                q.erase <= 1'b0;
            if (wr_hit)
                q.erase <= wdata[ERASE_BIT];

            // Set-only latch.
            if (wr_hit && wdata[SECURE_BIT])
                q.secure <= 1'b1;
        end
    end

endmodule

// File: rtl/fwc_route.sv
module fwc_route
    import fwc_pkg::*;
(
    input  logic   mov_wr,
    input  logic   mov_via_dptr,
    input  logic   pwe,
    output route_t route,
    output logic   flash_stb,
    output logic   ram_stb
);

    always_comb begin
        route     = pick_route(mov_wr, mov_via_dptr, pwe);
        flash_stb = (route == ROUTE_FLASH);
        ram_stb   = (route == ROUTE_RAM);
    end

endmodule

// File: rtl/fwc_rd_mux.sv
module fwc_rd_mux
    import fwc_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic              addr_hit,
    input  ctrl_t             ctrl,
    input  logic              preboot,
    input  logic [DW-1:0]     ext_in,
    output logic [BYTE_W-1:0] rdata,
    output logic [DW-1:0]     ext_out
);

    always_comb begin
        rdata   = addr_hit ? status_byte(ctrl, preboot) : '0;
        ext_out = ctrl.secure ? '0 : ext_in;
    end

endmodule

// File: rtl/fwc_flash_ctl.sv
module fwc_flash_ctl
    import fwc_pkg::*;
#(
    parameter logic [7:0]  SFR_ADDR = 8'hB2,
    parameter int unsigned DW       = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    sfr_addr,
    input  logic          sfr_wr,
    input  logic [7:0]    sfr_wdata,
    output logic [7:0]    sfr_rdata,
    input  logic          int_en,
    input  logic          mov_wr,
    input  logic          mov_via_dptr,
    output logic          flash_wr_stb,
    output logic          ram_wr_stb,
    input  logic          flash_byte_done,
    input  logic          erase_done,
    input  logic          preboot,
    output logic          pgm_wr_en,
    output logic          erase_req,
    output logic          secure,
    input  logic [DW-1:0] ext_rd_data_i,
    output logic [DW-1:0] ext_rd_data_o
);

    logic   addr_hit;
    logic   wr_hit;
    ctrl_t  ctrl_q;
    route_t route;

    assign addr_hit = (sfr_addr == SFR_ADDR);
    assign wr_hit   = sfr_wr && addr_hit;

    fwc_bit_ctrl u_bits (
        .clk        (clk),
        .rst        (rst),
        .wr_hit     (wr_hit),
        .wdata      (sfr_wdata),
        .int_en     (int_en),
        .byte_done  (flash_byte_done),
        .erase_done (erase_done),
        .q          (ctrl_q)
    );

    fwc_route u_route (
        .mov_wr       (mov_wr),
        .mov_via_dptr (mov_via_dptr),
        .pwe          (ctrl_q.pwe),
        .route        (route),
        .flash_stb    (flash_wr_stb),
        .ram_stb      (ram_wr_stb)
    );

    fwc_rd_mux #(.DW(DW)) u_rd (
        .addr_hit (addr_hit),
        .ctrl     (ctrl_q),
        .preboot  (preboot),
        .ext_in   (ext_rd_data_i),
        .rdata    (sfr_rdata),
        .ext_out  (ext_rd_data_o)
    );

    assign pgm_wr_en = ctrl_q.pwe;
    assign erase_req = ctrl_q.erase;
    assign secure    = ctrl_q.secure;

endmodule

// File: rtl/fwc_flash_ctl_chk.sv
module fwc_flash_ctl_chk #(
    parameter logic [7:0]  SFR_ADDR = 8'hB2,
    parameter int unsigned DW       = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [7:0]    sfr_addr,
    input logic          sfr_wr,
    input logic [7:0]    sfr_wdata,
    input logic [7:0]    sfr_rdata,
    input logic          int_en,
    input logic          mov_wr,
    input logic          flash_wr_stb,
    input logic          ram_wr_stb,
    input logic          flash_byte_done,
    input logic          erase_done,
    input logic          preboot,
    input logic          pgm_wr_en,
    input logic          erase_req,
    input logic          secure,
    input logic [DW-1:0] ext_rd_data_o
);

    logic hit_w;
    assign hit_w = sfr_wr && (sfr_addr == SFR_ADDR);

    // R5
    a_r5_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(flash_wr_stb && ram_wr_stb));
    a_r5_one_per_move: assert property (@(posedge clk) disable iff (rst)
        mov_wr |-> (flash_wr_stb || ram_wr_stb));
    a_r5_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !mov_wr |-> !(flash_wr_stb || ram_wr_stb));
    a_r5_flash_needs_pwe: assert property (@(posedge clk) disable iff (rst)
        flash_wr_stb |-> pgm_wr_en);
    // R3
    a_r3_ie_blocks_pwe: assert property (@(posedge clk) disable iff (rst)
        (int_en && hit_w && !flash_byte_done) |=> (pgm_wr_en == $past(pgm_wr_en)));
    // R4
    a_r4_done_clears: assert property (@(posedge clk) disable iff (rst)
        (flash_byte_done && !(hit_w && !int_en)) |=> !pgm_wr_en);
    // R6
    a_r6_erase_clears: assert property (@(posedge clk) disable iff (rst)
        (erase_done && !hit_w) |=> !erase_req);
    a_r6_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !sfr_rdata[1]);
    // R7
    a_r7_secure_sticky: assert property (@(posedge clk) disable iff (rst)
        secure |=> secure);
    // R8
    a_r8_preboot_view: assert property (@(posedge clk) disable iff (rst)
        (sfr_addr == SFR_ADDR) |-> (sfr_rdata[7] == preboot));
    // R9
    a_r9_masked: assert property (@(posedge clk) disable iff (rst)
        secure |-> (ext_rd_data_o == '0));
    // R10
    a_r10_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (sfr_addr != SFR_ADDR) |-> (sfr_rdata == 8'h00));

endmodule

bind fwc_flash_ctl fwc_flash_ctl_chk #(.SFR_ADDR(SFR_ADDR), .DW(DW)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .sfr_addr        (sfr_addr),
    .sfr_wr          (sfr_wr),
    .sfr_wdata       (sfr_wdata),
    .sfr_rdata       (sfr_rdata),
    .int_en          (int_en),
    .mov_wr          (mov_wr),
    .flash_wr_stb    (flash_wr_stb),
    .ram_wr_stb      (ram_wr_stb),
    .flash_byte_done (flash_byte_done),
    .erase_done      (erase_done),
    .preboot         (preboot),
    .pgm_wr_en       (pgm_wr_en),
    .erase_req       (erase_req),
    .secure          (secure),
    .ext_rd_data_o   (ext_rd_data_o)
);

// File: tb/fwc_flash_ctl_tb_top.sv
module fwc_flash_ctl_tb_top;

    localparam logic [7:0] ADDR = 8'hB2;
    localparam int unsigned DW  = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    sfr_addr = 8'h00;
    logic          sfr_wr = 1'b0;
    logic [7:0]    sfr_wdata = 8'h00;
    logic [7:0]    sfr_rdata;
    logic          int_en = 1'b0;
    logic          mov_wr = 1'b0;
    logic          mov_via_dptr = 1'b0;
    logic          flash_wr_stb;
    logic          ram_wr_stb;
    logic          flash_byte_done = 1'b0;
    logic          erase_done = 1'b0;
    logic          preboot = 1'b0;
    logic          pgm_wr_en;
    logic          erase_req;
    logic          secure;
    logic [DW-1:0] ext_rd_data_i = '0;
    logic [DW-1:0] ext_rd_data_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fwc_flash_ctl #(.SFR_ADDR(ADDR), .DW(DW)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .sfr_addr        (sfr_addr),
        .sfr_wr          (sfr_wr),
        .sfr_wdata       (sfr_wdata),
        .sfr_rdata       (sfr_rdata),
        .int_en          (int_en),
        .mov_wr          (mov_wr),
        .mov_via_dptr    (mov_via_dptr),
        .flash_wr_stb    (flash_wr_stb),
        .ram_wr_stb      (ram_wr_stb),
        .flash_byte_done (flash_byte_done),
        .erase_done      (erase_done),
        .preboot         (preboot),
        .pgm_wr_en       (pgm_wr_en),
        .erase_req       (erase_req),
        .secure          (secure),
        .ext_rd_data_i   (ext_rd_data_i),
        .ext_rd_data_o   (ext_rd_data_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One write cycle; on return the registered result is visible.
    task automatic sfr_write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0; sfr_addr = ADDR;
    endtask

    task automatic t_reset;
        preboot = 1'b1; sfr_addr = ADDR;
        #1;
        check("R1 pgm_wr_en", pgm_wr_en, 0);
        check("R1 erase_req", erase_req, 0);
        check("R1 secure", secure, 0);
        check("R1 rdata", sfr_rdata, 32'h80);
        preboot = 1'b0;
    endtask

    task automatic t_pwe_write;
        sfr_write(ADDR, 8'h01);
        check("R2 pwe set", pgm_wr_en, 1);
        check("R2 rdata bit0", sfr_rdata, 32'h01);
        sfr_write(8'hB3, 8'h00);
        check("R2 other addr ignored", pgm_wr_en, 1);
        sfr_write(ADDR, 8'h00);
        check("R2 pwe clear", pgm_wr_en, 0);
    endtask

    task automatic t_ie_block;
        int_en = 1'b1;
        sfr_write(ADDR, 8'h03);
        check("R3 pwe blocked", pgm_wr_en, 0);
        check("R3 erase still armed", erase_req, 1);
        sfr_write(ADDR, 8'h00);
        int_en = 1'b0;
        sfr_write(ADDR, 8'h01);
        int_en = 1'b1;
        sfr_write(ADDR, 8'h00);
        check("R3 pwe clear blocked", pgm_wr_en, 1);
        int_en = 1'b0;
    endtask

    task automatic t_steer;
        // pgm_wr_en is 1 here.
        @(negedge clk);
        mov_wr = 1'b1; mov_via_dptr = 1'b1; #1;
        check("R5 flash stb", {flash_wr_stb, ram_wr_stb}, 2'b10);
        mov_via_dptr = 1'b0; #1;
        check("R5 non-dptr to ram", {flash_wr_stb, ram_wr_stb}, 2'b01);
        mov_wr = 1'b0; #1;
        check("R5 idle", {flash_wr_stb, ram_wr_stb}, 2'b00);
    endtask

    task automatic t_byte_done;
        @(negedge clk);
        flash_byte_done = 1'b1;
        @(negedge clk);
        flash_byte_done = 1'b0;
        check("R4 done clears", pgm_wr_en, 0);
        mov_wr = 1'b1; mov_via_dptr = 1'b1; #1;
        check("R5 ram after clear", {flash_wr_stb, ram_wr_stb}, 2'b01);
        mov_wr = 1'b0;
        sfr_write(ADDR, 8'h01);
        @(negedge clk);
        flash_byte_done = 1'b1; sfr_addr = ADDR; sfr_wdata = 8'h01; sfr_wr = 1'b1;
        @(negedge clk);
        flash_byte_done = 1'b0; sfr_wr = 1'b0;
        check("R4 write wins", pgm_wr_en, 1);
        sfr_write(ADDR, 8'h00);
    endtask

    task automatic t_erase;
        sfr_write(ADDR, 8'h02);
        check("R6 armed", erase_req, 1);
        check("R6 reads 0", sfr_rdata, 32'h00);
        @(negedge clk);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
        check("R6 consumed", erase_req, 0);
        @(negedge clk);
        check("R6 stays clear", erase_req, 0);
        sfr_write(ADDR, 8'h02);
        @(negedge clk);
        erase_done = 1'b1; sfr_addr = ADDR; sfr_wdata = 8'h02; sfr_wr = 1'b1;
        @(negedge clk);
        erase_done = 1'b0; sfr_wr = 1'b0;
        check("R6 rearm wins", erase_req, 1);
        sfr_write(ADDR, 8'h00);
        check("R6 write 0 disarms", erase_req, 0);
    endtask

    task automatic t_secure_mask;
        ext_rd_data_i = 32'hDEAD_BEEF; #1;
        check("R9 pass", ext_rd_data_o, 32'hDEAD_BEEF);
        sfr_write(ADDR, 8'h40);
        check("R7 set", secure, 1);
        check("R7 rdata", sfr_rdata, 32'h40);
        check("R9 masked", ext_rd_data_o, 0);
        sfr_write(ADDR, 8'h00);
        check("R7 zero ignored", secure, 1);
    endtask

    task automatic t_preboot_misc;
        sfr_write(ADDR, 8'hBC);
        check("R10 spare bits zero", sfr_rdata, 32'h40);
        check("R8 bit7 write ignored", sfr_rdata[7], 0);
        preboot = 1'b1; #1;
        check("R8 follows input", sfr_rdata[7], 1);
        sfr_addr = 8'h12; #1;
        check("R10 miss zero", sfr_rdata, 0);
        sfr_addr = ADDR;
        preboot = 1'b0;
    endtask

    task automatic t_reset_again;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R7 reset clears secure", secure, 0);
        check("R1 reset rdata", sfr_rdata, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        t_pwe_write;
        t_ie_block;
        t_steer;
        t_byte_done;
        t_erase;
        t_secure_mask;
        t_preboot_misc;
        t_reset_again;
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule